// File: doc/BRIEF.md
# Card Transfer Command Launcher

This block runs one card transfer per command for a flash-card host. Software sets up a transfer through a small word-addressed register port and then writes a command word. The command word carries an 8-bit protocol code, a read/write direction, a data-path select and card-interrupt wait flags. The block first sends the protocol code to the card and then moves the payload. It finishes by raising an end-of-data event and an end-of-command event.

Two data paths exist. Payloads of up to eight bytes never touch the FIFO: the bytes sit in two 32-bit parameter registers, packed little-endian. Longer payloads are sized by a block register, which holds a block size and a block count. These bytes stream through a 32-bit FIFO that software fills or drains through a data port. The card side is a plain byte handshake: the block holds a request, and a byte moves on each clock edge where request and acknowledge are both high.

Register word addresses: 0 command, 1 parameter 0, 2 parameter 1, 3 block, 4 data port, 5 status. Status bits: bit 0 busy, bit 1 FIFO empty, bit 2 FIFO full.

Top module: `card_cmd_launcher`

## Requirements
- R1: A command-register write while idle starts a transfer. The first card handshake carries the protocol code (command bits [23:16]) with `card_code` and `card_wr` high, and only then do data bytes move.
- R2: A command-register write while busy is ignored. No second code byte is sent, the running transfer is unchanged, and the command register still reads the accepted word.
- R3: `busy` and status bit 0 go high the cycle after an accepted command write. They stay high through the cycle in which end-of-command pulses and are low the cycle after.
- R4: With command bit 15 clear, the short path is used. The length is command bits [3:0], and any value above 8 counts as 8. On a write, byte k is taken little-endian from parameter 0 (k<4) or parameter 1 (k>=4), so byte 0 is parameter 0 bits [7:0].
- R5: A short read (bit 15 clear, bit 14 set) leaves both parameter registers unchanged until end-of-command. At end-of-command they load the received bytes little-endian, and every byte position at or beyond the length reads zero.
- R6: With bit 15 set, the FIFO path moves exactly size x count bytes. The size is block register bits [11:0] and the count is bits [31:16]. On a write, the bytes are taken from FIFO words in little-endian order, and a word is consumed once its last needed byte is sent.
- R7: A FIFO read packs received bytes little-endian into 32-bit words read at the data port, and the final partial word is padded with zero. When the FIFO is full and a word must be stored, the card request is withheld until software reads a word.
- R8: In FIFO mode, end-of-data pulses in the cycle of the final byte handshake and end-of-command pulses strictly later. In short mode, both pulse together in a single cycle. Each event is a one-cycle pulse.
- R9: After the data phase, the block waits for `card_int` before end-of-command when the mode flag asks for it. In serial mode (`bus_parallel` low) the flag is command bit 11; in parallel mode it is command bit 13. The flag that does not match the mode has no effect.
- R10: A zero-length transfer, in either path, sends only the code byte and still raises both events.
- R11: After reset: idle, no card request, parameter registers zero, status reads FIFO empty only (value 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops FIFO at data port) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| bus_parallel | input | 1 | Card bus is in a parallel mode |
| card_req | output | 1 | Byte transfer request to card |
| card_wr | output | 1 | Byte goes host to card |
| card_code | output | 1 | Current byte is the protocol code |
| card_wdata | output | 8 | Byte to card |
| card_ack | input | 1 | Card accepts/supplies a byte |
| card_rdata | input | 8 | Byte from card |
| card_int | input | 1 | Card interrupt line |
| evt_cmd_end | output | 1 | End-of-command pulse |
| evt_data_end | output | 1 | End-of-data pulse |
| busy | output | 1 | Command in progress |

## Verification
The case hardest to reach from the ports is back-pressure on a FIFO read. The card must be stopped mid-word because the FIFO is full, and then restart cleanly when software frees a slot. The bench starts a 38-byte read and reads nothing until more than eight words' worth of bytes could have arrived. At that point it checks that the request is low and that status shows busy and full. It then drains a few words, lets the transfer finish and reads the rest, which includes the zero-padded last word. The bench also holds a short read with a slow card so that it can read the parameter registers mid-transfer.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_CMD  = 3'd0;
    localparam logic [REG_AW-1:0] RA_P0   = 3'd1;
    localparam logic [REG_AW-1:0] RA_P1   = 3'd2;
    localparam logic [REG_AW-1:0] RA_BLK  = 3'd3;
    localparam logic [REG_AW-1:0] RA_DATA = 3'd4;
    localparam logic [REG_AW-1:0] RA_STAT = 3'd5;

    // command word layout; the code field and flag positions are decoded by the engine
    typedef struct packed {
        logic [7:0] rsvd_hi;
        logic [7:0] code;
        logic       fifo_sel;
        logic       dir_rd;
        logic       wait_int;
        logic       rsvd_12;
        logic       get_int;
        logic [6:0] rsvd_lo;
        logic [3:0] short_len;
    } cmd_word_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CODE = 3'd1,
        ST_DATA = 3'd2,
        ST_WAIT = 3'd3,
        ST_FIN  = 3'd4
    } eng_state_e;
endpackage

// File: rtl/ccl_fifo.sv
module ccl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_s;

    fifo_s q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == (AW+1)'(DEPTH));
    assign rdata = mem[q.rp];

    always_comb begin
        d       = q;
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        if (do_push) d.wp = nxt(q.wp);
        if (do_pop)  d.rp = nxt(q.rp);
        if (do_push && !do_pop) d.cnt = q.cnt + 1'b1;
        else if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end
endmodule

// File: rtl/ccl_engine.sv
module ccl_engine
    import ccl_pkg::*;
#(
    parameter int SIZE_W = 12,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        code,
    input  logic              fifo_sel,
    input  logic              dir_rd,
    input  logic              wait_int,
    input  logic              get_int,
    input  logic [3:0]        short_len,
    input  logic [SIZE_W-1:0] blk_size,
    input  logic [CNT_W-1:0]  blk_cnt,
    input  logic              bus_parallel,
    input  logic [63:0]       prm_wr_data,
    output logic [63:0]       prm_rd_data,
    output logic              prm_load,
    output logic              card_req,
    output logic              card_wr,
    output logic              card_code,
    output logic [7:0]        card_wdata,
    input  logic              card_ack,
    input  logic [7:0]        card_rdata,
    input  logic              card_int,
    input  logic [31:0]       fifo_rdata,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic              fifo_pop,
    output logic              fifo_push,
    output logic [31:0]       fifo_wdata,
    output logic              evt_cmd_end,
    output logic              evt_data_end,
    output logic              busy
);
    localparam int TOT_W   = SIZE_W + CNT_W;
    localparam int SHORT_MAX = 8;

    typedef struct packed {
        eng_state_e       st;
        logic [7:0]       code;
        logic             fmode;
        logic             rd;
        logic             need_int;
        logic [TOT_W-1:0] total;
        logic [TOT_W-1:0] idx;
        logic [63:0]      shadow;
        logic [31:0]      acc;
    } eng_s;

    eng_s q, d;
    logic [1:0] lane;
    logic       last, wrap, moved;

    assign busy        = (q.st != ST_IDLE);
    assign prm_rd_data = q.shadow;

    always_comb begin
        d            = q;
        card_req     = 1'b0;
        card_wr      = 1'b0;
        card_code    = 1'b0;
        card_wdata   = '0;
        fifo_pop     = 1'b0;
        fifo_push    = 1'b0;
        fifo_wdata   = '0;
        evt_cmd_end  = 1'b0;
        evt_data_end = 1'b0;
        prm_load     = 1'b0;
        moved        = 1'b0;
        lane         = q.idx[1:0];
        last         = (q.idx == q.total - TOT_W'(1));
        wrap         = (lane == 2'd3) || last;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_CODE;
                    d.code     = code;
                    d.fmode    = fifo_sel;
                    d.rd       = dir_rd;
                    d.need_int = bus_parallel ? wait_int : get_int;
                    d.idx      = '0;
                    d.shadow   = '0;
                    d.acc      = '0;
                    if (fifo_sel)
                        d.total = TOT_W'(blk_size) * TOT_W'(blk_cnt);
                    else if (short_len > 4'(SHORT_MAX))
                        d.total = TOT_W'(SHORT_MAX);
                    else
                        d.total = TOT_W'(short_len);
                end
            end
            ST_CODE: begin
                card_req   = 1'b1;
                card_wr    = 1'b1;
                card_code  = 1'b1;
                card_wdata = q.code;
                if (card_ack) begin
                    if (q.total == '0) begin
                        evt_data_end = q.fmode;
                        d.st = q.need_int ? ST_WAIT : ST_FIN;
                    end else begin
                        d.st = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (q.fmode && !q.rd) begin
                    card_req   = !fifo_empty;
                    card_wr    = 1'b1;
                    card_wdata = fifo_rdata[{lane, 3'b000} +: 8];
                    moved      = card_req && card_ack;
                    fifo_pop   = moved && wrap;
                end else if (q.fmode) begin
                    card_req = !(wrap && fifo_full);
                    moved    = card_req && card_ack;
                    if (moved) begin
                        if (wrap) begin
                            fifo_push  = 1'b1;
                            fifo_wdata = q.acc | (32'(card_rdata) << {lane, 3'b000});
                            d.acc      = '0;
                        end else begin
                            d.acc[{lane, 3'b000} +: 8] = card_rdata;
                        end
                    end
                end else if (!q.rd) begin
                    card_req   = 1'b1;
                    card_wr    = 1'b1;
                    card_wdata = prm_wr_data[{q.idx[2:0], 3'b000} +: 8];
                    moved      = card_ack;
                end else begin
                    card_req = 1'b1;
                    moved    = card_ack;
                    if (moved) d.shadow[{q.idx[2:0], 3'b000} +: 8] = card_rdata;
                end
                if (moved) begin
                    if (last) begin
                        evt_data_end = q.fmode;
                        d.st = q.need_int ? ST_WAIT : ST_FIN;
                    end else begin
                        d.idx = q.idx + TOT_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (card_int) d.st = ST_FIN;
            end
            ST_FIN: begin
                evt_cmd_end  = 1'b1;
                evt_data_end = !q.fmode;
                prm_load     = !q.fmode && q.rd;
                d.st         = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/card_cmd_launcher.sv
module card_cmd_launcher
    import ccl_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int SIZE_W     = 12,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              bus_parallel,
    output logic              card_req,
    output logic              card_wr,
    output logic              card_code,
    output logic [7:0]        card_wdata,
    input  logic              card_ack,
    input  logic [7:0]        card_rdata,
    input  logic              card_int,
    output logic              evt_cmd_end,
    output logic              evt_data_end,
    output logic              busy
);
    localparam int CNT_LSB = 16;

    typedef struct packed {
        cmd_word_t   cmd;
        logic [31:0] prm0;
        logic [31:0] prm1;
        logic [31:0] blk;
    } top_s;

    top_s q, d;

    logic        start;
    logic [63:0] prm_rd_data;
    logic        prm_load;
    logic [31:0] fifo_rdata, eng_wdata, fifo_wdata;
    logic        fifo_empty, fifo_full;
    logic        eng_pop, eng_push, sw_push, sw_pop;

    assign start   = bus_wr && (bus_addr == RA_CMD) && !busy;
    assign sw_push = bus_wr && (bus_addr == RA_DATA) && !eng_push;
    assign sw_pop  = bus_rd && (bus_addr == RA_DATA) && !eng_pop;
    assign fifo_wdata = eng_push ? eng_wdata : bus_wdata;

    always_comb begin
        d = q;
        if (start) d.cmd = cmd_word_t'(bus_wdata);
        if (bus_wr && bus_addr == RA_BLK) d.blk = bus_wdata;
        if (prm_load) begin
            d.prm0 = prm_rd_data[31:0];
            d.prm1 = prm_rd_data[63:32];
        end else if (bus_wr) begin
            if (bus_addr == RA_P0) d.prm0 = bus_wdata;
            if (bus_addr == RA_P1) d.prm1 = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (bus_addr)
            RA_CMD:  bus_rdata = q.cmd;
            RA_P0:   bus_rdata = q.prm0;
            RA_P1:   bus_rdata = q.prm1;
            RA_BLK:  bus_rdata = q.blk;
            RA_DATA: bus_rdata = fifo_rdata;
            RA_STAT: bus_rdata = {29'd0, fifo_full, fifo_empty, busy};
            default: bus_rdata = '0;
        endcase
    end

    ccl_fifo #(
        .W     (32),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (eng_push | sw_push),
        .wdata (fifo_wdata),
        .pop   (eng_pop | sw_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    ccl_engine #(
        .SIZE_W (SIZE_W),
        .CNT_W  (CNT_W)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .code         (bus_wdata[23:16]),
        .fifo_sel     (bus_wdata[15]),
        .dir_rd       (bus_wdata[14]),
        .wait_int     (bus_wdata[13]),
        .get_int      (bus_wdata[11]),
        .short_len    (bus_wdata[3:0]),
        .blk_size     (q.blk[SIZE_W-1:0]),
        .blk_cnt      (q.blk[CNT_LSB +: CNT_W]),
        .bus_parallel (bus_parallel),
        .prm_wr_data  ({q.prm1, q.prm0}),
        .prm_rd_data  (prm_rd_data),
        .prm_load     (prm_load),
        .card_req     (card_req),
        .card_wr      (card_wr),
        .card_code    (card_code),
        .card_wdata   (card_wdata),
        .card_ack     (card_ack),
        .card_rdata   (card_rdata),
        .card_int     (card_int),
        .fifo_rdata   (fifo_rdata),
        .fifo_empty   (fifo_empty),
        .fifo_full    (fifo_full),
        .fifo_pop     (eng_pop),
        .fifo_push    (eng_push),
        .fifo_wdata   (eng_wdata),
        .evt_cmd_end  (evt_cmd_end),
        .evt_data_end (evt_data_end),
        .busy         (busy)
    );
endmodule

// File: rtl/card_cmd_launcher_chk.sv
module card_cmd_launcher_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        bus_wr,
    input logic        card_req,
    input logic        card_code,
    input logic        evt_cmd_end,
    input logic        evt_data_end,
    input logic [31:0] prm0,
    input logic [31:0] prm1
);
    AST_CODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (card_req && card_code)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!card_req && !evt_cmd_end && !evt_data_end)); // R3

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !evt_cmd_end) |=> busy); // R3

    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_cmd_end |=> !busy); // R3

    AST_DATA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_data_end |=> !evt_data_end); // R8

    AST_PRM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !evt_cmd_end && !bus_wr) |=> ($stable(prm0) && $stable(prm1))); // R5
endmodule

bind card_cmd_launcher card_cmd_launcher_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .bus_wr       (bus_wr),
    .card_req     (card_req),
    .card_code    (card_code),
    .evt_cmd_end  (evt_cmd_end),
    .evt_data_end (evt_data_end),
    .prm0         (q.prm0),
    .prm1         (q.prm1)
);

// File: tb/card_cmd_launcher_bench.sv
module card_cmd_launcher_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_parallel = 1'b0;
    logic        card_req, card_wr, card_code, card_ack;
    logic [7:0]  card_wdata, card_rdata;
    logic        card_int = 1'b0;
    logic        evt_cmd_end, evt_data_end, busy;

    int tests = 0, fails = 0;
    int cyc = 0, code_n = 0, wn = 0, rn = 0;
    int ncmd = 0, cmd_cyc = 0, data_cyc = 0, exp_ncmd = 0;
    logic [7:0] last_code = '0;
    logic [7:0] wlog [64];
    logic [7:0] rx_base = 8'h00;
    logic slow = 1'b0, ack_en = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_cmd_launcher u_card_cmd_launcher (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_parallel(bus_parallel), .card_req(card_req), .card_wr(card_wr),
        .card_code(card_code), .card_wdata(card_wdata), .card_ack(card_ack),
        .card_rdata(card_rdata), .card_int(card_int), .evt_cmd_end(evt_cmd_end),
        .evt_data_end(evt_data_end), .busy(busy)
    );

    // card stub
    assign card_ack   = card_req & ack_en;
    assign card_rdata = rx_base + rn[7:0];

    always @(negedge clk) ack_en <= slow ? ~ack_en : 1'b1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (card_req && card_ack) begin
            if (card_code) begin
                code_n    <= code_n + 1;
                last_code <= card_wdata;
            end else if (card_wr) begin
                wlog[wn[5:0]] <= card_wdata;
                wn <= wn + 1;
            end else begin
                rn <= rn + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (evt_data_end) data_cyc = cyc;
        if (evt_cmd_end) begin
            cmd_cyc = cyc;
            ncmd++;
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung (actual timeout, expected completion)");
        finish_run();
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic start_cmd(input logic [31:0] w);
        exp_ncmd = ncmd + 1;
        reg_wr(3'd0, w);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (ncmd < exp_ncmd && n < 2000) begin
            @(negedge clk); #2;
            n++;
        end
        check({tag, " completion"}, 32'(ncmd >= exp_ncmd), 32'd1);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input logic [7:0] code, input logic dsel, input logic rd,
                                       input logic wi, input logic gi, input logic [3:0] len);
        return {8'h00, code, dsel, rd, wi, 1'b0, gi, 7'h00, len};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(3'd5, v); check("R11 status after reset", v, 32'h2);
        reg_rd(3'd1, v); check("R11 param0 after reset", v, 32'h0);
        check("R11 busy/req after reset", {30'd0, busy, card_req}, 32'h0);
    endtask

    task automatic t_short_write();
        int w0, c0;
        reg_wr(3'd1, 32'h44332211);
        reg_wr(3'd2, 32'h88776655);
        w0 = wn; c0 = code_n;
        start_cmd(mk(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5));
        wait_done("R4 short write");
        check("R1 one code byte", 32'(code_n - c0), 32'd1);
        check("R1 code value", 32'(last_code), 32'hA5);
        check("R4 short write count", 32'(wn - w0), 32'd5);
        for (int i = 0; i < 5; i++)
            check("R4 short write byte", 32'(wlog[(w0 + i) & 63]), 32'(8'h11 * (i + 1)));
        check("R8 short events same cycle", 32'(cmd_cyc - data_cyc), 32'd0);
    endtask

    task automatic t_short_read_clamp();
        int r0;
        logic [31:0] v;
        rx_base = 8'h40; r0 = rn;
        start_cmd(mk(8'h4B, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9));
        wait_done("R4 clamp read");
        check("R4 clamp byte count", 32'(rn - r0), 32'd8);
        reg_rd(3'd1, v);
        check("R5 clamp param0", v, {8'(8'h40+r0+3), 8'(8'h40+r0+2), 8'(8'h40+r0+1), 8'(8'h40+r0)});
        reg_rd(3'd2, v);
        check("R5 clamp param1", v, {8'(8'h40+r0+7), 8'(8'h40+r0+6), 8'(8'h40+r0+5), 8'(8'h40+r0+4)});
    endtask

    task automatic t_short_read_partial();
        int r0;
        logic [31:0] v;
        reg_wr(3'd1, 32'hDEADBEEF);
        reg_wr(3'd2, 32'hCAFEF00D);
        rx_base = 8'hC0; r0 = rn; slow = 1'b1;
        start_cmd(mk(8'h4C, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3));
        repeat (2) @(negedge clk);
        reg_rd(3'd1, v);
        check("R5 param0 held mid-read", v, 32'hDEADBEEF);
        wait_done("R5 partial read");
        slow = 1'b0;
        reg_rd(3'd1, v);
        check("R5 param0 loaded, top byte zero", v, {8'h00, 8'(8'hC0+r0+2), 8'(8'hC0+r0+1), 8'(8'hC0+r0)});
        reg_rd(3'd2, v);
        check("R5 param1 zero beyond length", v, 32'h0);
    endtask

    task automatic t_busy_ignore();
        int w0, c0;
        logic [31:0] v, first;
        reg_wr(3'd1, 32'h03020100);
        reg_wr(3'd2, 32'h07060504);
        w0 = wn; c0 = code_n; slow = 1'b1;
        first = mk(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8);
        start_cmd(first);
        repeat (3) @(negedge clk);
        reg_wr(3'd0, mk(8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1));
        reg_rd(3'd5, v);
        check("R3 status busy mid-transfer", v & 32'h1, 32'h1);
        wait_done("R2 busy ignore");
        slow = 1'b0;
        check("R2 single code byte", 32'(code_n - c0), 32'd1);
        check("R2 code kept", 32'(last_code), 32'h5A);
        check("R2 full length kept", 32'(wn - w0), 32'd8);
        reg_rd(3'd0, v);
        check("R2 command register kept", v, first);
        reg_rd(3'd5, v);
        check("R3 status idle after end", v & 32'h1, 32'h0);
    endtask

    task automatic t_fifo_write();
        int w0;
        logic [31:0] v;
        reg_wr(3'd3, (32'd1 << 16) | 32'd6);
        reg_wr(3'd4, 32'h04030201);
        reg_wr(3'd4, 32'h00000605);
        w0 = wn;
        start_cmd(mk(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0));
        wait_done("R6 fifo write");
        check("R6 fifo write count", 32'(wn - w0), 32'd6);
        for (int i = 0; i < 6; i++)
            check("R6 fifo write byte", 32'(wlog[(w0 + i) & 63]), 32'(i + 1));
        check("R8 fifo cmd after data", 32'(cmd_cyc - data_cyc), 32'd1);
        reg_rd(3'd5, v);
        check("R6 fifo drained", v, 32'h2);
    endtask

    task automatic t_fifo_read_multi();
        int r0;
        logic [31:0] v;
        rx_base = 8'hB0; r0 = rn;
        reg_wr(3'd3, (32'd2 << 16) | 32'd3);
        start_cmd(mk(8'h2D, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0));
        wait_done("R6 fifo read");
        check("R6 size x count bytes", 32'(rn - r0), 32'd6);
        check("R8 fifo read cmd after data", 32'(cmd_cyc - data_cyc), 32'd1);
        reg_rd(3'd4, v);
        check("R7 word0", v, {8'(8'hB0+r0+3), 8'(8'hB0+r0+2), 8'(8'hB0+r0+1), 8'(8'hB0+r0)});
        reg_rd(3'd4, v);
        check("R7 padded word1", v, {16'h0000, 8'(8'hB0+r0+5), 8'(8'hB0+r0+4)});
    endtask

    function automatic logic [31:0] exp_word(input int r0, input int k, input int len);
        logic [31:0] w = '0;
        for (int b = 0; b < 4; b++)
            if (4*k + b < len) w[8*b +: 8] = 8'(r0 + 4*k + b);
        return w;
    endfunction

    task automatic t_fifo_stall();
        int r0;
        logic [31:0] v;
        rx_base = 8'h00; r0 = rn;
        reg_wr(3'd3, (32'd1 << 16) | 32'd38);
        start_cmd(mk(8'h6E, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0));
        repeat (40) @(negedge clk);
        #1;
        check("R7 request withheld when full", 32'(card_req), 32'd0);
        reg_rd(3'd5, v);
        check("R7 status busy and full", v, 32'h5);
        for (int k = 0; k < 2; k++) begin
            reg_rd(3'd4, v);
            check("R7 stalled word", v, exp_word(r0, k, 38));
        end
        wait_done("R7 stall");
        for (int k = 2; k < 10; k++) begin
            reg_rd(3'd4, v);
            check("R7 stalled word", v, exp_word(r0, k, 38));
        end
        reg_rd(3'd5, v);
        check("R7 fifo empty after drain", v, 32'h2);
    endtask

    task automatic t_int();
        logic [31:0] v;
        int n0;
        bus_parallel = 1'b0;
        start_cmd(mk(8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1));
        repeat (20) @(negedge clk);
        n0 = ncmd;
        reg_rd(3'd5, v);
        check("R9 serial waits on bit11", v & 32'h1, 32'h1);
        check("R9 no end before int", 32'(ncmd - n0 + (exp_ncmd - ncmd)), 32'd1);
        card_int = 1'b1;
        wait_done("R9 serial int");
        card_int = 1'b0;
        start_cmd(mk(8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1));
        wait_done("R9 serial ignores bit13");
        bus_parallel = 1'b1;
        start_cmd(mk(8'h12, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1));
        wait_done("R9 parallel ignores bit11");
        start_cmd(mk(8'h13, 1'b0, 1'b0, 1'b1, 1'b0, 4'd1));
        repeat (20) @(negedge clk);
        reg_rd(3'd5, v);
        check("R9 parallel waits on bit13", v & 32'h1, 32'h1);
        card_int = 1'b1;
        wait_done("R9 parallel int");
        card_int = 1'b0;
        bus_parallel = 1'b0;
    endtask

    task automatic t_zero();
        int w0, c0;
        w0 = wn; c0 = code_n;
        start_cmd(mk(8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0));
        wait_done("R10 short zero");
        check("R10 short zero code only", 32'(code_n - c0), 32'd1);
        check("R10 short zero no data", 32'(wn - w0), 32'd0);
        check("R10 short zero events together", 32'(cmd_cyc - data_cyc), 32'd0);
        reg_wr(3'd3, (32'd1 << 16));
        start_cmd(mk(8'h21, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0));
        wait_done("R10 fifo zero");
        check("R10 fifo zero no data", 32'(wn - w0), 32'd0);
        check("R10 fifo zero data before cmd", 32'(cmd_cyc - data_cyc), 32'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_write();
        t_short_read_clamp();
        t_short_read_partial();
        t_busy_ignore();
        t_fifo_write();
        t_fifo_read_multi();
        t_fifo_stall();
        t_int();
        t_zero();
        finish_run();
    end
endmodule